// File: doc/BRIEF.md
# Floppy Card Local Control Logic

This block is the register glue that sits next to a floppy disk controller chip on an add-in card. The host reaches it through simple register strobes. One write-only command byte selects one of four drives, switches the spindle motor of small-format drives, gates the card interrupt, sets the direction of buffer transfers and holds the controller chip in reset. A read-only status byte at the same index reports four things: whether the medium has changed, whether the controller has raised an interrupt, whether the selected drive is ready, and whether the attached drive is of the large 8-inch format.

Two more indices front a small on-card static RAM. One holds an address counter, which the host can load and read back. The other is a data port that reads or writes the RAM at the counter address and then advances the counter by one. A whole sector can therefore be streamed through a single index. No access has back-pressure. Every strobe completes in the cycle it is sampled. Read data appears on the next edge and stays there until the next read. The host never asserts read and write in the same cycle.

Top module: `fdc_card_glue`

## Requirements
- R1: After reset the command byte is 0x00. No drive is selected, the motor output is on, the controller reset, DMA direction and interrupt outputs are low, the buffer counter is 0, and the status byte has bit 1 = 1 and bit 0 = 0.
- R2: Command bit 2 enables selection and bits 1:0 give the drive number. When bit 2 = 1 and bit 7 = 0, `drv_sel_o` is one-hot at that drive number (0x04 selects drive 0). Otherwise `drv_sel_o` is all zero.
- R3: Command bit 3 = 1 turns the motor off. `motor_on_o` is the inverse of bit 3, except that it is always 1 while `eight_inch_i` is high.
- R4: `fdc_rst_o` follows command bit 7 and `dma_rd_o` follows command bit 6 (1 = the controller reads the buffer). 0x80 resets with no drive selected. 0x48 gives motor off, no selection and DMA read.
- R5: Status bit 0 is set by a high `disk_chg_i`. It is cleared by a command write that changes bit 2 from 1 to 0. When both happen in the same cycle, the set wins.
- R6: Status bit 1 reads 0 from the cycle after `fdc_int_i` is high. A status read clears the flag, but the byte returned by that read still shows the flag. If `fdc_int_i` is high in the same cycle as the read, the flag stays set.
- R7: `irq_o` is high only while command bit 5 is 1 and the interrupt flag of R6 is set. Writing bit 5 = 0 masks the output but does not clear the flag.
- R8: Status bit 6 reads 0 only when a drive is selected and its `drv_rdy_i` bit is high. Bit 7 equals `eight_inch_i`. Bits 5:2 read 0.
- R9: A write to index 4 loads the buffer counter. A read of index 4 returns the counter.
- R10: A write to index 6 stores the data at the counter address and increments the counter. A read of index 6 returns the RAM byte at the counter and increments the counter. The counter wraps from the top of the RAM to 0.
- R11: `bus_rdata` is loaded on the edge that samples `bus_rd` and holds until the next read. A read of any index other than 4, 6 or 8 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register index |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| drv_sel_o | output | 4 | One-hot drive select |
| motor_on_o | output | 1 | Spindle motor on |
| fdc_rst_o | output | 1 | Reset to the controller chip |
| dma_rd_o | output | 1 | Transfer direction, 1 = controller reads the buffer |
| irq_o | output | 1 | Interrupt to the host |
| fdc_int_i | input | 1 | Interrupt request from the controller chip |
| disk_chg_i | input | 1 | Medium-change pulse from the drive |
| drv_rdy_i | input | 4 | Ready line of each drive |
| eight_inch_i | input | 1 | High when the attached drive is 8-inch |

## Verification
A medium-change pulse and a deselecting command write can reach the change latch on the same clock edge. The bench provokes this by raising `disk_chg_i` during the write of 0x01 that follows 0x05. It then reads the status and expects bit 0 = 1, because the set must win. The interrupt capture and the status read that clears it can also coincide. The bench holds `fdc_int_i` high through a status read and expects the following read to still show bit 1 = 0.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_DRV = 4;
  localparam int SEL_W   = $clog2(NUM_DRV);

  localparam logic [ADDR_W-1:0] IDX_CNT = 4'd4;
  localparam logic [ADDR_W-1:0] IDX_BUF = 4'd6;
  localparam logic [ADDR_W-1:0] IDX_LCL = 4'd8;

  localparam int B_SEL_EN = 2;
  localparam int B_MOTOFF = 3;
  localparam int B_IRQEN  = 5;
  localparam int B_DMARD  = 6;
  localparam int B_CRST   = 7;

  typedef struct packed {
    logic             crst;
    logic             dma_rd;
    logic             irq_en;
    logic             motor_off;
    logic             sel_en;
    logic [SEL_W-1:0] sel;
  } ctl_word_t;
endpackage

// File: rtl/lcl_cmd_reg.sv
module lcl_cmd_reg
  import fdc_glue_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wdata,
  output ctl_word_t          ctl_q,
  output logic               sel_en_fall,
  output logic [NUM_DRV-1:0] drv_sel
);
  ctl_word_t ctl_d;

  always_comb begin
    ctl_d.crst      = wdata[B_CRST];
    ctl_d.dma_rd    = wdata[B_DMARD];
    ctl_d.irq_en    = wdata[B_IRQEN];
    ctl_d.motor_off = wdata[B_MOTOFF];
    ctl_d.sel_en    = wdata[B_SEL_EN];
    ctl_d.sel       = wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_d;
  end

  assign sel_en_fall = wr_en & ctl_q.sel_en & ~ctl_d.sel_en;

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_sel
    assign drv_sel[g] = ctl_q.sel_en & ~ctl_q.crst & (ctl_q.sel == SEL_W'(g));
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_sel)); // R2
endmodule

// File: rtl/lcl_stat_latch.sv
module lcl_stat_latch
  import fdc_glue_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disk_chg_i,
  input  logic               sel_en_fall,
  input  logic               fdc_int_i,
  input  logic               stat_rd,
  input  logic [NUM_DRV-1:0] drv_sel,
  input  logic [NUM_DRV-1:0] drv_rdy_i,
  input  logic               eight_inch_i,
  output logic [7:0]         stat_byte,
  output logic               irq_pend
);
  logic chg_q;
  logic sel_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)           chg_q <= 1'b0;
    else if (disk_chg_i)  chg_q <= 1'b1;
    else if (sel_en_fall) chg_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          irq_pend <= 1'b0;
    else if (fdc_int_i)  irq_pend <= 1'b1;
    else if (stat_rd)    irq_pend <= 1'b0;
  end

  assign sel_ready = |(drv_sel & drv_rdy_i);
  assign stat_byte = {eight_inch_i, ~sel_ready, 4'b0000, ~irq_pend, chg_q};

  AST_CHG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    disk_chg_i |=> chg_q); // R5
  AST_CHG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en_fall && !disk_chg_i) |=> !chg_q); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !stat_rd) |=> irq_pend); // R6
endmodule

// File: rtl/buf_port.sv
module buf_port #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_cnt,
  input  logic              wr_port,
  input  logic              rd_port,
  input  logic [DATA_W-1:0] wdata,
  output logic [AW-1:0]     cnt_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (ld_cnt)             cnt_q <= wdata[AW-1:0];
    else if (wr_port || rd_port) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_port) mem[cnt_q] <= wdata;
  end

  assign rd_data = mem[cnt_q];

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> cnt_q == $past(wdata[AW-1:0])); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_port || rd_port) && !ld_cnt) |=> cnt_q == AW'($past(cnt_q) + 1'b1)); // R10
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_cnt || wr_port || rd_port) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/fdc_card_glue.sv
module fdc_card_glue
  import fdc_glue_pkg::*;
#(
  parameter int BUF_DEPTH = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [NUM_DRV-1:0] drv_sel_o,
  output logic               motor_on_o,
  output logic               fdc_rst_o,
  output logic               dma_rd_o,
  output logic               irq_o,
  input  logic               fdc_int_i,
  input  logic               disk_chg_i,
  input  logic [NUM_DRV-1:0] drv_rdy_i,
  input  logic               eight_inch_i
);
  localparam int CW = $clog2(BUF_DEPTH);

  ctl_word_t   ctl_q;
  logic        sel_en_fall;
  logic [7:0]  stat_byte;
  logic        irq_pend;
  logic [CW-1:0] cnt_q;
  logic [7:0]  buf_rd;

  logic wr_lcl, rd_lcl, wr_cnt, wr_buf, rd_buf;
  assign wr_lcl = bus_wr && bus_addr == IDX_LCL;
  assign rd_lcl = bus_rd && bus_addr == IDX_LCL;
  assign wr_cnt = bus_wr && bus_addr == IDX_CNT;
  assign wr_buf = bus_wr && bus_addr == IDX_BUF;
  assign rd_buf = bus_rd && bus_addr == IDX_BUF;

  lcl_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_lcl), .wdata(bus_wdata),
    .ctl_q(ctl_q), .sel_en_fall(sel_en_fall), .drv_sel(drv_sel_o)
  );

  lcl_stat_latch u_stat (
    .clk(clk), .rst_n(rst_n), .disk_chg_i(disk_chg_i), .sel_en_fall(sel_en_fall),
    .fdc_int_i(fdc_int_i), .stat_rd(rd_lcl), .drv_sel(drv_sel_o),
    .drv_rdy_i(drv_rdy_i), .eight_inch_i(eight_inch_i),
    .stat_byte(stat_byte), .irq_pend(irq_pend)
  );

  buf_port #(.DEPTH(BUF_DEPTH), .DATA_W(8)) u_buf (
    .clk(clk), .rst_n(rst_n), .ld_cnt(wr_cnt), .wr_port(wr_buf),
    .rd_port(rd_buf), .wdata(bus_wdata), .cnt_q(cnt_q), .rd_data(buf_rd)
  );

  assign motor_on_o = ~ctl_q.motor_off | eight_inch_i;
  assign fdc_rst_o  = ctl_q.crst;
  assign dma_rd_o   = ctl_q.dma_rd;
  assign irq_o      = ctl_q.irq_en & irq_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (bus_addr)
        IDX_CNT: bus_rdata <= 8'(cnt_q);
        IDX_BUF: bus_rdata <= buf_rd;
        IDX_LCL: bus_rdata <= stat_byte;
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_RST_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_rst_o |-> stat_byte[6]); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

// File: tb/fdc_card_glue_tb_top.sv
module fdc_card_glue_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] drv_sel_o;
  logic       motor_on_o, fdc_rst_o, dma_rd_o, irq_o;
  logic       fdc_int_i = 1'b0, disk_chg_i = 1'b0, eight_inch_i = 1'b0;
  logic [3:0] drv_rdy_i = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fdc_card_glue dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_sel_o(drv_sel_o),
    .motor_on_o(motor_on_o), .fdc_rst_o(fdc_rst_o), .dma_rd_o(dma_rd_o), .irq_o(irq_o),
    .fdc_int_i(fdc_int_i), .disk_chg_i(disk_chg_i), .drv_rdy_i(drv_rdy_i),
    .eight_inch_i(eight_inch_i)
  );

  // {cmd[15:8], eight_inch[7], sel[6:3], motor[2], crst[1], dma[0]}
  localparam logic [15:0] VEC [11] = '{
    16'h040C, 16'h0514, 16'h0624, 16'h0744, 16'h0304, 16'h4801,
    16'h4885, 16'h8006, 16'h8706, 16'h0D10, 16'h6EA5
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 sel", {4'h0, drv_sel_o}, 8'h00);
    chk("R1 outs", {4'h0, motor_on_o, fdc_rst_o, dma_rd_o, irq_o}, 8'h08);
    rd(4'd8, d); chk("R1 status", d, 8'h42);
    rd(4'd4, d); chk("R1 counter", d, 8'h00);

    // R2 R3 R4 command decode table
    foreach (VEC[i]) begin
      eight_inch_i = VEC[i][7];
      wr(4'd8, VEC[i][15:8]);
      chk("R2 sel", {4'h0, drv_sel_o}, {4'h0, VEC[i][6:3]});
      chk("R3 motor", {7'h0, motor_on_o}, {7'h0, VEC[i][2]});
      chk("R4 rst/dma", {6'h0, fdc_rst_o, dma_rd_o}, {6'h0, VEC[i][1:0]});
    end

    // R8 ready and size
    eight_inch_i = 1'b0; drv_rdy_i = 4'b0010;
    wr(4'd8, 8'h05);
    rd(4'd8, d); chk("R8 ready", d, 8'h02);
    eight_inch_i = 1'b1;
    rd(4'd8, d); chk("R8 eight", d, 8'h82);
    drv_rdy_i = 4'b0001;
    rd(4'd8, d); chk("R8 other ready", d, 8'hC2);
    eight_inch_i = 1'b0;

    // R5 change latch
    @(negedge clk); disk_chg_i = 1'b1; @(negedge clk); disk_chg_i = 1'b0;
    rd(4'd8, d); chk("R5 set", d & 8'h01, 8'h01);
    wr(4'd8, 8'h05);
    rd(4'd8, d); chk("R5 kept", d & 8'h01, 8'h01);
    wr(4'd8, 8'h01);
    rd(4'd8, d); chk("R5 clear", d & 8'h01, 8'h00);
    wr(4'd8, 8'h05);
    @(negedge clk); bus_addr = 4'd8; bus_wdata = 8'h01; bus_wr = 1'b1; disk_chg_i = 1'b1;
    @(negedge clk); bus_wr = 1'b0; disk_chg_i = 1'b0;
    rd(4'd8, d); chk("R5 set wins", d & 8'h01, 8'h01);

    // R6 R7 interrupt
    wr(4'd8, 8'h20);
    chk("R7 idle", {7'h0, irq_o}, 8'h00);
    @(negedge clk); fdc_int_i = 1'b1; @(negedge clk); fdc_int_i = 1'b0;
    chk("R7 raised", {7'h0, irq_o}, 8'h01);
    rd(4'd8, d); chk("R6 flag", d & 8'h02, 8'h00);
    rd(4'd8, d); chk("R6 cleared", d & 8'h02, 8'h02);
    chk("R7 dropped", {7'h0, irq_o}, 8'h00);
    wr(4'd8, 8'h00);
    @(negedge clk); fdc_int_i = 1'b1; @(negedge clk); fdc_int_i = 1'b0;
    chk("R7 masked", {7'h0, irq_o}, 8'h00);
    wr(4'd8, 8'h20);
    chk("R7 unmasked", {7'h0, irq_o}, 8'h01);
    fdc_int_i = 1'b1;
    rd(4'd8, d);
    fdc_int_i = 1'b0;
    rd(4'd8, d); chk("R6 set wins", d & 8'h02, 8'h00);

    // R9 R10 buffer
    wr(4'd4, 8'hFE);
    rd(4'd4, d); chk("R9 load", d, 8'hFE);
    wr(4'd6, 8'hA1); wr(4'd6, 8'hB2); wr(4'd6, 8'hC3);
    rd(4'd4, d); chk("R10 wrap", d, 8'h01);
    wr(4'd4, 8'hFE);
    rd(4'd6, d); chk("R10 rd0", d, 8'hA1);
    rd(4'd6, d); chk("R10 rd1", d, 8'hB2);
    rd(4'd6, d); chk("R10 rd2", d, 8'hC3);
    rd(4'd4, d); chk("R10 count", d, 8'h01);

    // R11 hold and unused index
    repeat (3) @(negedge clk);
    chk("R11 hold", bus_rdata, 8'h01);
    rd(4'd2, d); chk("R11 unused", d, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule